// File: doc/BRIEF.md
# Non-isochronous OUT endpoint receive controller

This block holds the per-endpoint transfer state for a group of non-isochronous OUT endpoints on a full-speed USB device. Software arms an endpoint by writing its remaining byte budget, the number of packets it expects and the data toggle it expects next. Arming also clears the endpoint's NAK condition. A packet decoder then reports each finished data packet with its endpoint number, data PID, CRC result and payload length, together with a flag that says whether the receive FIFO can hold it. For every packet the block picks a handshake (none, ACK or NAK) and tells the FIFO to keep the speculatively written bytes (commit) or to drop them (flush).

When a packet is kept, the packet budget drops by one and the byte budget drops by the payload length. The byte budget stops at zero and does not wrap. The expected toggle flips. A packet whose PID does not match the expected toggle is a retransmission of a packet that was already kept: the block acknowledges it and drops it without touching the budgets. The endpoint falls back into NAK and raises a one-cycle completion pulse when its packet budget runs out or when a payload shorter than the maximum packet size arrives, including a zero-length one. Software reads the budgets back through a read port and works out the received byte and packet totals by subtraction.

Top module: `usb_oep_ctrl`

## Requirements
- R1: After reset every endpoint is in NAK with byte budget 0, packet budget 0 and expected toggle DATA0 (0); hs_code is 0 (no reply) and fifo_commit, fifo_flush and xfer_done are all 0.
- R2: A cycle with cfg_wr high loads cfg_size, cfg_cnt and cfg_tog into endpoint cfg_ep and clears its NAK; the read port shows the new values after that clock edge.
- R3: A packet with pkt_crc_ok low is flushed and gets no handshake (hs_code 0), whatever the other inputs are, and no endpoint state changes.
- R4: A packet with a good CRC to an endpoint in NAK is flushed and answered with NAK (hs_code 2), and the state stays unchanged.
- R5: A packet with a good CRC to an armed endpoint while pkt_room is low is flushed and answered with NAK, and the state stays unchanged.
- R6: A packet with a good CRC to an armed endpoint with room, whose PID (0 = DATA0, 1 = DATA1) differs from the expected toggle, is flushed and answered with ACK (hs_code 1). The budgets and the toggle stay unchanged and no completion pulse is raised.
- R7: A packet with a good CRC to an armed endpoint with room and the expected PID is committed and answered with ACK. The packet budget drops by 1, the byte budget drops by pkt_len, and the toggle flips.
- R8: A kept packet that brings the packet budget from 1 to 0 puts the endpoint into NAK and pulses its xfer_done bit.
- R9: A kept packet with pkt_len below MAX_PKT, including length 0, puts the endpoint into NAK and pulses its xfer_done bit.
- R10: The byte budget stops at 0 when a kept payload is larger than what remains.
- R11: Each packet produces exactly one of fifo_commit or fifo_flush, together with hs_code, in the cycle after pkt_vld. With no packet, both are 0 and hs_code is 0. A bad CRC takes precedence over NAK, NAK takes precedence over lack of room, and lack of room takes precedence over the toggle check.
- R12: A packet or a configuration write changes only the endpoint it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Arm strobe |
| cfg_ep | input | EP_W | Endpoint to arm |
| cfg_size | input | SIZE_W | Byte budget to load |
| cfg_cnt | input | CNT_W | Packet budget to load |
| cfg_tog | input | 1 | Expected toggle to load |
| pkt_vld | input | 1 | End-of-data-packet event |
| pkt_ep | input | EP_W | Endpoint of the packet |
| pkt_pid | input | 1 | Data PID, 0 = DATA0, 1 = DATA1 |
| pkt_crc_ok | input | 1 | Data CRC matched |
| pkt_room | input | 1 | Receive FIFO can hold the packet |
| pkt_len | input | LEN_W | Payload length in bytes |
| hs_code | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK |
| fifo_commit | output | 1 | Keep the packet in the FIFO |
| fifo_flush | output | 1 | Drop the packet from the FIFO |
| xfer_done | output | NUM_EP | Per-endpoint completion pulse |
| rd_ep | input | EP_W | Endpoint selected for readback |
| rd_size | output | SIZE_W | Remaining byte budget |
| rd_cnt | output | CNT_W | Remaining packet budget |
| rd_nak | output | 1 | Endpoint is in NAK |
| rd_tog | output | 1 | Expected next toggle |

## Verification
The hardest case to reach is a retransmission. It needs a kept packet on an armed endpoint that still has budget left and a FIFO with room, followed by the same PID again on the same endpoint. Most other combinations end the transfer or get NAK first. The directed part builds this case explicitly. The random part biases PIDs toward the expected toggle and re-arms endpoints that have finished, with the toggle they left behind, so that packets kept in a row are regularly followed by stale PIDs. Repeated bytes of budget left after a short packet and budgets set smaller than one payload cover the saturation case.

// File: rtl/usb_oep_pkg.sv
package usb_oep_pkg;
   typedef enum logic [1:0] {
      HS_NONE = 2'b00,
      HS_ACK  = 2'b01,
      HS_NAK  = 2'b10
   } hs_e;

   typedef enum logic [1:0] {
      VERD_DROP,
      VERD_NAK,
      VERD_DUP,
      VERD_TAKE
   } verd_e;
endpackage

// File: rtl/oep_judge.sv
module oep_judge
   import usb_oep_pkg::*;
#(
   parameter int MAX_PKT = 64,
   parameter int LEN_W   = 7
) (
   input  logic             crc_ok,
   input  logic             armed,
   input  logic             room,
   input  logic             pid,
   input  logic             tog,
   input  logic [LEN_W-1:0] len,
   output verd_e            verdict,
   output logic             short_pkt
);
   localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_PKT);

   assign short_pkt = (len < FULL_LEN);

   always_comb begin
      if (!crc_ok)
         verdict = VERD_DROP;
      else if (!armed)
         verdict = VERD_NAK;
      else if (!room)
         verdict = VERD_NAK;
      else if (pid != tog)
         verdict = VERD_DUP;
      else
         verdict = VERD_TAKE;
   end
endmodule

// File: rtl/oep_ep_regs.sv
module oep_ep_regs #(
   parameter int SIZE_W = 19,
   parameter int CNT_W  = 10,
   parameter int LEN_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [SIZE_W-1:0] ld_size,
   input  logic [CNT_W-1:0]  ld_cnt,
   input  logic              ld_tog,
   input  logic              take,
   input  logic [LEN_W-1:0]  take_len,
   input  logic              take_short,
   output logic              armed,
   output logic [SIZE_W-1:0] size,
   output logic [CNT_W-1:0]  cnt,
   output logic              tog,
   output logic              done
);
   if (SIZE_W <= LEN_W) begin : g_bad_size_w
      $error("SIZE_W must exceed LEN_W");
   end

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [SIZE_W-1:0] len_ext;
   logic              last_pkt;

   assign len_ext  = {{(SIZE_W-LEN_W){1'b0}}, take_len};
   assign last_pkt = (cnt <= CNT_ONE) || take_short;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         size  <= '0;
         cnt   <= '0;
         tog   <= 1'b0;
         done  <= 1'b0;
      end else if (ld) begin
         armed <= 1'b1;
         size  <= ld_size;
         cnt   <= ld_cnt;
         tog   <= ld_tog;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (take && armed) begin
            cnt  <= (cnt == '0) ? '0 : cnt - CNT_ONE;
            size <= (size > len_ext) ? size - len_ext : '0;
            tog  <= ~tog;
            if (last_pkt) begin
               armed <= 1'b0;
               done  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/usb_oep_ctrl.sv
module usb_oep_ctrl
   import usb_oep_pkg::*;
#(
   parameter int NUM_EP  = 4,
   parameter int MAX_PKT = 64,
   parameter int SIZE_W  = 19,
   parameter int CNT_W   = 10,
   localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
   localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [EP_W-1:0]   cfg_ep,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  logic              cfg_tog,
   input  logic              pkt_vld,
   input  logic [EP_W-1:0]   pkt_ep,
   input  logic              pkt_pid,
   input  logic              pkt_crc_ok,
   input  logic              pkt_room,
   input  logic [LEN_W-1:0]  pkt_len,
   output logic [1:0]        hs_code,
   output logic              fifo_commit,
   output logic              fifo_flush,
   output logic [NUM_EP-1:0] xfer_done,
   input  logic [EP_W-1:0]   rd_ep,
   output logic [SIZE_W-1:0] rd_size,
   output logic [CNT_W-1:0]  rd_cnt,
   output logic              rd_nak,
   output logic              rd_tog
);
   if (NUM_EP < 1) begin : g_bad_num_ep
      $error("NUM_EP must be at least 1");
   end
   if (MAX_PKT < 1 || MAX_PKT > 1023) begin : g_bad_max_pkt
      $error("MAX_PKT out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("CNT_W must be at least 1");
   end

   logic [NUM_EP-1:0] ep_armed;
   logic [NUM_EP-1:0] ep_tog;
   logic [SIZE_W-1:0] ep_size [NUM_EP];
   logic [CNT_W-1:0]  ep_cnt  [NUM_EP];

   logic  sel_armed;
   logic  sel_tog;
   verd_e verdict;
   logic  short_pkt;

   // state of the addressed endpoint; an unmatched index reads as NAK
   always_comb begin
      sel_armed = 1'b0;
      sel_tog   = 1'b0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (pkt_ep == EP_W'(i)) begin
            sel_armed = ep_armed[i];
            sel_tog   = ep_tog[i];
         end
      end
   end

   oep_judge #(
      .MAX_PKT (MAX_PKT),
      .LEN_W   (LEN_W)
   ) u_judge (
      .crc_ok    (pkt_crc_ok),
      .armed     (sel_armed),
      .room      (pkt_room),
      .pid       (pkt_pid),
      .tog       (sel_tog),
      .len       (pkt_len),
      .verdict   (verdict),
      .short_pkt (short_pkt)
   );

   for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
      logic ld_g;
      logic take_g;
      assign ld_g   = cfg_wr && (cfg_ep == EP_W'(g));
      assign take_g = pkt_vld && (pkt_ep == EP_W'(g)) && (verdict == VERD_TAKE);

      oep_ep_regs #(
         .SIZE_W (SIZE_W),
         .CNT_W  (CNT_W),
         .LEN_W  (LEN_W)
      ) u_regs (
         .clk        (clk),
         .rst_n      (rst_n),
         .ld         (ld_g),
         .ld_size    (cfg_size),
         .ld_cnt     (cfg_cnt),
         .ld_tog     (cfg_tog),
         .take       (take_g),
         .take_len   (pkt_len),
         .take_short (short_pkt),
         .armed      (ep_armed[g]),
         .size       (ep_size[g]),
         .cnt        (ep_cnt[g]),
         .tog        (ep_tog[g]),
         .done       (xfer_done[g])
      );
   end

   // registered reply, one cycle after the packet event
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_code     <= HS_NONE;
         fifo_commit <= 1'b0;
         fifo_flush  <= 1'b0;
      end else if (pkt_vld) begin
         case (verdict)
            VERD_TAKE: begin
               hs_code     <= HS_ACK;
               fifo_commit <= 1'b1;
               fifo_flush  <= 1'b0;
            end
            VERD_DUP: begin
               hs_code     <= HS_ACK;
               fifo_commit <= 1'b0;
               fifo_flush  <= 1'b1;
            end
            VERD_NAK: begin
               hs_code     <= HS_NAK;
               fifo_commit <= 1'b0;
               fifo_flush  <= 1'b1;
            end
            default: begin
               hs_code     <= HS_NONE;
               fifo_commit <= 1'b0;
               fifo_flush  <= 1'b1;
            end
         endcase
      end else begin
         hs_code     <= HS_NONE;
         fifo_commit <= 1'b0;
         fifo_flush  <= 1'b0;
      end
   end

   // software readback
   always_comb begin
      rd_size = '0;
      rd_cnt  = '0;
      rd_nak  = 1'b1;
      rd_tog  = 1'b0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (rd_ep == EP_W'(i)) begin
            rd_size = ep_size[i];
            rd_cnt  = ep_cnt[i];
            rd_nak  = ~ep_armed[i];
            rd_tog  = ep_tog[i];
         end
      end
   end
endmodule

// File: rtl/usb_oep_chk.sv
module usb_oep_chk
   import usb_oep_pkg::*;
#(
   parameter int NUM_EP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pkt_vld,
   input logic              pkt_crc_ok,
   input logic              pkt_room,
   input logic [1:0]        hs_code,
   input logic              fifo_commit,
   input logic              fifo_flush,
   input logic [NUM_EP-1:0] xfer_done,
   input logic [NUM_EP-1:0] ep_armed
);
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_vld |=> (fifo_commit ^ fifo_flush)); // R11

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_vld |=> (!fifo_commit && !fifo_flush && hs_code == HS_NONE)); // R11

   AST_COMMIT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_commit |-> hs_code == HS_ACK); // R7

   AST_BAD_CRC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_vld && !pkt_crc_ok) |=> (fifo_flush && hs_code == HS_NONE)); // R3

   AST_NO_ROOM_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_vld && !pkt_room) |=> !fifo_commit); // R5

   for (genvar g = 0; g < NUM_EP; g++) begin : g_ep_chk
      AST_DONE_SETS_NAK: assert property (@(posedge clk) disable iff (!rst_n)
         xfer_done[g] |-> !ep_armed[g]); // R8

      AST_DONE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
         xfer_done[g] |-> fifo_commit); // R9
   end
endmodule

bind usb_oep_ctrl usb_oep_chk #(.NUM_EP(NUM_EP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pkt_vld     (pkt_vld),
   .pkt_crc_ok  (pkt_crc_ok),
   .pkt_room    (pkt_room),
   .hs_code     (hs_code),
   .fifo_commit (fifo_commit),
   .fifo_flush  (fifo_flush),
   .xfer_done   (xfer_done),
   .ep_armed    (ep_armed)
);

// File: tb/usb_oep_ctrl_bench.sv
module usb_oep_ctrl_bench;
   localparam int NUM_EP  = 4;
   localparam int MAX_PKT = 64;
   localparam int SIZE_W  = 19;
   localparam int CNT_W   = 10;
   localparam int EP_W    = 2;
   localparam int LEN_W   = 7;
   localparam int PAD     = MAX_PKT + 4 - (MAX_PKT % 4);

   logic              clk;
   logic              rst_n;
   logic              cfg_wr;
   logic [EP_W-1:0]   cfg_ep;
   logic [SIZE_W-1:0] cfg_size;
   logic [CNT_W-1:0]  cfg_cnt;
   logic              cfg_tog;
   logic              pkt_vld;
   logic [EP_W-1:0]   pkt_ep;
   logic              pkt_pid;
   logic              pkt_crc_ok;
   logic              pkt_room;
   logic [LEN_W-1:0]  pkt_len;
   logic [1:0]        hs_code;
   logic              fifo_commit;
   logic              fifo_flush;
   logic [NUM_EP-1:0] xfer_done;
   logic [EP_W-1:0]   rd_ep;
   logic [SIZE_W-1:0] rd_size;
   logic [CNT_W-1:0]  rd_cnt;
   logic              rd_nak;
   logic              rd_tog;

   usb_oep_ctrl #(
      .NUM_EP  (NUM_EP),
      .MAX_PKT (MAX_PKT),
      .SIZE_W  (SIZE_W),
      .CNT_W   (CNT_W)
   ) u_usb_oep_ctrl (
      .clk (clk), .rst_n (rst_n),
      .cfg_wr (cfg_wr), .cfg_ep (cfg_ep), .cfg_size (cfg_size),
      .cfg_cnt (cfg_cnt), .cfg_tog (cfg_tog),
      .pkt_vld (pkt_vld), .pkt_ep (pkt_ep), .pkt_pid (pkt_pid),
      .pkt_crc_ok (pkt_crc_ok), .pkt_room (pkt_room), .pkt_len (pkt_len),
      .hs_code (hs_code), .fifo_commit (fifo_commit), .fifo_flush (fifo_flush),
      .xfer_done (xfer_done),
      .rd_ep (rd_ep), .rd_size (rd_size), .rd_cnt (rd_cnt),
      .rd_nak (rd_nak), .rd_tog (rd_tog)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   bit m_armed [NUM_EP];
   int m_size  [NUM_EP];
   int m_cnt   [NUM_EP];
   bit m_tog   [NUM_EP];
   int checks;
   int fails;

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic string verdict_tag(bit crc, bit armed, bit room, bit pid, bit tog);
      if (!crc) return "R3";
      if (!armed) return "R4";
      if (!room) return "R5";
      if (pid != tog) return "R6";
      return "R7";
   endfunction

   function automatic int exp_hs(string tag);
      if (tag == "R3") return 0;
      if (tag == "R4" || tag == "R5") return 2;
      return 1;
   endfunction

   task automatic check_ep(int e, string tag);
      rd_ep = EP_W'(e);
      #1;
      chk({tag, " nak"},  int'(rd_nak), int'(!m_armed[e]));
      chk({tag, " size"}, int'(rd_size), m_size[e]);
      chk({tag, " cnt"},  int'(rd_cnt), m_cnt[e]);
      chk({tag, " tog"},  int'(rd_tog), int'(m_tog[e]));
   endtask

   task automatic check_all(int tgt, string tag);
      for (int e = 0; e < NUM_EP; e++)
         check_ep(e, (e == tgt) ? tag : "R12 other endpoint");
   endtask

   task automatic arm(int e, int size, int cnt, bit tog);
      @(negedge clk);
      cfg_wr   = 1'b1;
      cfg_ep   = EP_W'(e);
      cfg_size = SIZE_W'(size);
      cfg_cnt  = CNT_W'(cnt);
      cfg_tog  = tog;
      @(negedge clk);
      cfg_wr = 1'b0;
      m_armed[e] = 1'b1;
      m_size[e]  = size;
      m_cnt[e]   = cnt;
      m_tog[e]   = tog;
      check_all(e, "R2 arm");
   endtask

   task automatic send(int e, bit pid, bit crc, bit room, int len);
      string tag;
      int    done_exp;
      bit    take;
      tag  = verdict_tag(crc, m_armed[e], room, pid, m_tog[e]);
      take = (tag == "R7");
      done_exp = 0;
      @(negedge clk);
      pkt_vld    = 1'b1;
      pkt_ep     = EP_W'(e);
      pkt_pid    = pid;
      pkt_crc_ok = crc;
      pkt_room   = room;
      pkt_len    = LEN_W'(len);
      @(negedge clk);
      pkt_vld = 1'b0;
      chk({tag, " hs_code"}, int'(hs_code), exp_hs(tag));
      chk({tag, " commit"}, int'(fifo_commit), int'(take));
      chk({tag, " flush"}, int'(fifo_flush), int'(!take));
      chk("R11 single action", int'(fifo_commit) + int'(fifo_flush), 1);
      if (take) begin
         if (m_cnt[e] <= 1 || len < MAX_PKT) begin
            m_armed[e] = 1'b0;
            done_exp   = 1 << e;
            tag = (m_cnt[e] <= 1) ? "R8" : "R9";
         end
         m_cnt[e]  = (m_cnt[e] == 0) ? 0 : m_cnt[e] - 1;
         m_size[e] = (m_size[e] > len) ? m_size[e] - len : 0;
         m_tog[e]  = ~m_tog[e];
      end
      chk({tag, " xfer_done"}, int'(xfer_done), done_exp);
      check_all(e, tag);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      checks = 0;
      fails  = 0;
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_ep = '0; cfg_size = '0; cfg_cnt = '0;
      cfg_tog = 1'b0; pkt_vld = 1'b0; pkt_ep = '0; pkt_pid = 1'b0;
      pkt_crc_ok = 1'b0; pkt_room = 1'b0; pkt_len = '0; rd_ep = '0;
      for (int e = 0; e < NUM_EP; e++) begin
         m_armed[e] = 1'b0; m_size[e] = 0; m_cnt[e] = 0; m_tog[e] = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk("R1 hs_code", int'(hs_code), 0);
      chk("R1 commit", int'(fifo_commit), 0);
      chk("R1 flush", int'(fifo_flush), 0);
      chk("R1 xfer_done", int'(xfer_done), 0);
      check_all(0, "R1 reset state");
      rst_n = 1'b1;

      // directed: full transfer on endpoint 0
      arm(0, 2 * PAD, 2, 1'b0);
      send(0, 1'b0, 1'b1, 1'b1, MAX_PKT);   // kept
      send(0, 1'b0, 1'b1, 1'b1, MAX_PKT);   // retransmission
      send(0, 1'b1, 1'b0, 1'b1, MAX_PKT);   // bad CRC
      send(0, 1'b1, 1'b1, 1'b0, MAX_PKT);   // no room
      send(0, 1'b1, 1'b1, 1'b1, MAX_PKT);   // last packet
      send(0, 1'b0, 1'b1, 1'b1, MAX_PKT);   // endpoint in NAK

      // short and zero-length packets
      arm(1, 3 * PAD, 3, 1'b0);
      send(1, 1'b0, 1'b1, 1'b1, 10);
      arm(2, 2 * PAD, 2, 1'b1);
      send(2, 1'b1, 1'b1, 1'b1, 0);

      // R10: byte budget stops at zero
      arm(3, 30, 4, 1'b0);
      send(3, 1'b0, 1'b1, 1'b1, MAX_PKT);
      check_ep(3, "R10 saturated size");
      chk("R10 size zero", int'(rd_size), 0);
      send(3, 1'b1, 1'b1, 1'b1, 5);
      chk("R10 size stays zero", int'(rd_size), 0);

      // R11 priority: bad CRC over no room over stale PID
      arm(0, 2 * PAD, 2, 1'b0);
      send(0, 1'b1, 1'b0, 1'b0, MAX_PKT);
      chk("R11 crc first", int'(hs_code), 0);
      send(0, 1'b1, 1'b1, 1'b0, MAX_PKT);
      chk("R11 room before toggle", int'(hs_code), 2);

      // constrained random traffic
      void'($urandom(32'd7741));
      for (int it = 0; it < 400; it++) begin
         int e;
         bit pid;
         bit crc;
         bit room;
         int len;
         e = int'($urandom % NUM_EP);
         if (!m_armed[e] && ($urandom % 4) != 0) begin
            int n;
            n = 1 + int'($urandom % 5);
            arm(e, n * PAD, n, m_tog[e]);
         end
         pid  = (($urandom % 4) != 0) ? m_tog[e] : ~m_tog[e];
         crc  = (($urandom % 10) != 0);
         room = (($urandom % 7) != 0);
         len  = (($urandom % 10) < 7) ? MAX_PKT : int'($urandom % (MAX_PKT + 1));
         send(e, pid, crc, room, len);
      end

      finish_run();
   end
endmodule